// File: doc/BRIEF.md
# Two-Class Interrupt Router

This block gathers a wide set of level-sensitive peripheral request lines and turns them into two processor interrupt lines: a normal-class line and a fast-class line. Every source has a sticky pending flag that captures a request and keeps it until software clears it. It also has a class-select bit that sends the source to one of the two lines, a mask bit that stops forwarding, and a 4-bit urgency value. For each class a separate arbiter picks the most urgent unmasked pending source. The winning source number is registered next to that class's output line.

Software reaches every field through a word-addressed synchronous register bus. Writes take effect on the clock edge on which they are presented. Read data is combinational from the current address. The two output lines are computed independently of each other, so the fast line can rise while the normal line is already asserted.

Top module: `irc_ctrl`

## Requirements
- R1: After reset every class bit is 0 (normal class), every mask bit is 1, every pending bit is 0, every urgency field is 0, both output lines are low, and both index registers read 127.
- R2: A source whose request line is high at a rising clock edge has its pending bit set from that edge on, and the bit remains set after the request line drops.
- R3: Writing a pending word clears every bit written as 1 and leaves bits written as 0 unchanged. A request that is high in the same cycle as a clear of its bit keeps the bit set.
- R4: A source is eligible when its pending bit is 1 and its mask bit is 0. Its class bit (1 = fast, 0 = normal) picks the output. Each output line is registered: it rises on the edge after an eligible pending bit becomes visible, and it falls on the edge after the last eligible source of its class is cleared, masked or moved.
- R5: Within a class the eligible source with the numerically lowest urgency value wins. Among equal values the lower source number wins.
- R6: The normal-class index register (word 32) and the fast-class index register (word 33) hold the winning source number in bits [6:0], and upper bits read 0. They update on the same edge as their output line, and read 127 when the class has no eligible source.
- R7: The two classes are arbitrated and driven independently. The fast line asserts while the normal line stays asserted whenever both classes have eligible sources.
- R8: Word address map, bit b of word k holding source 32k+b: class bits at words 0-2, mask bits at words 4-6, pending bits at words 8-10. Urgency of source n sits at word 16+n/8, bits [4(n%8)+3 : 4(n%8)]. Bits above source 89 read 0 and ignore writes, and unmapped words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req | input | 90 | Level request line per source, bit n is source n |
| bus_wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| irq_o | output | 1 | Normal-class interrupt line |
| fiq_o | output | 1 | Fast-class interrupt line |

## Verification
A request sampled at edge k shows in the pending word right after edge k. The output line and index register that it drives change right after edge k+1. A bus write changes configuration or clears pending at its own edge, and the lines follow one edge later. The bench drives all inputs on the falling edge. A behavioural model updates on the rising edge from the same inputs. Line levels are compared on every falling edge, and register reads are sampled a few nanoseconds after a falling edge, once the combinational read path has settled.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 6;

  // word bases of the register map
  localparam int unsigned A_CLS  = 0;
  localparam int unsigned A_MSK  = 4;
  localparam int unsigned A_PND  = 8;
  localparam int unsigned A_URG  = 16;
  localparam int unsigned A_NIDX = 32;
  localparam int unsigned A_FIDX = 33;

  // class numbering
  localparam int unsigned CLS_NORM = 0;
  localparam int unsigned CLS_FAST = 1;
  localparam int unsigned NUM_CLS  = 2;
endpackage

// File: rtl/irc_regs.sv
module irc_regs
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 90,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned IDX_W   = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src_req,
  input  logic                      wr_en,
  input  logic [BUS_AW-1:0]         addr,
  input  logic [BUS_DW-1:0]         wdata,
  input  logic [IDX_W-1:0]          norm_idx,
  input  logic [IDX_W-1:0]          fast_idx,
  output logic [BUS_DW-1:0]         rdata,
  output logic [NUM_SRC-1:0]        cls_q,
  output logic [NUM_SRC-1:0]        msk_q,
  output logic [NUM_SRC-1:0]        pnd_q,
  output logic [NUM_SRC*PRIO_W-1:0] urg_q
);
  localparam int unsigned PER_WORD = BUS_DW / PRIO_W;

  logic [NUM_SRC-1:0]        cls_d, msk_d, pnd_d, clr_vec;
  logic [NUM_SRC*PRIO_W-1:0] urg_d;
  logic                      cfg_en;
  logic                      past_ok_q;

  // next-state: configuration writes and pending set/clear
  always_comb begin
    cls_d   = cls_q;
    msk_d   = msk_q;
    urg_d   = urg_q;
    clr_vec = '0;
    cfg_en  = wr_en;
    if (wr_en) begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (addr == BUS_AW'(A_CLS + s / 32)) cls_d[s]   = wdata[s % 32];
        if (addr == BUS_AW'(A_MSK + s / 32)) msk_d[s]   = wdata[s % 32];
        if (addr == BUS_AW'(A_PND + s / 32)) clr_vec[s] = wdata[s % 32];
        if (addr == BUS_AW'(A_URG + s / PER_WORD))
          urg_d[s*PRIO_W +: PRIO_W] = wdata[(s % PER_WORD)*PRIO_W +: PRIO_W];
      end
    end
    // a live request overrides a clear in the same cycle
    pnd_d = (pnd_q & ~clr_vec) | src_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cls_q <= '0;
      msk_q <= '1;
      urg_q <= '0;
    end else if (cfg_en) begin
      cls_q <= cls_d;
      msk_q <= msk_d;
      urg_q <= urg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pnd_q <= '0;
    else        pnd_q <= pnd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  // read path
  always_comb begin
    rdata = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (addr == BUS_AW'(A_CLS + s / 32)) rdata[s % 32] = cls_q[s];
      if (addr == BUS_AW'(A_MSK + s / 32)) rdata[s % 32] = msk_q[s];
      if (addr == BUS_AW'(A_PND + s / 32)) rdata[s % 32] = pnd_q[s];
      if (addr == BUS_AW'(A_URG + s / PER_WORD))
        rdata[(s % PER_WORD)*PRIO_W +: PRIO_W] = urg_q[s*PRIO_W +: PRIO_W];
    end
    if (addr == BUS_AW'(A_NIDX)) rdata[IDX_W-1:0] = norm_idx;
    if (addr == BUS_AW'(A_FIDX)) rdata[IDX_W-1:0] = fast_idx;
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> ((($past(pnd_q) & ~$past(clr_vec)) & ~pnd_q) == '0)); // R2

  AST_SET_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (($past(src_req) & ~pnd_q) == '0)); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> (($past(clr_vec) & ~$past(src_req) & pnd_q) == '0)); // R3
endmodule

// File: rtl/irc_arbiter.sv
module irc_arbiter #(
  parameter int unsigned NUM_SRC = 90,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned IDX_W   = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        elig,
  input  logic [NUM_SRC*PRIO_W-1:0] urg,
  output logic                      win_vld,
  output logic [IDX_W-1:0]          win_idx
);
  logic [PRIO_W-1:0] best_urg;

  // ascending scan, strict compare keeps the lower number on ties
  always_comb begin
    win_vld  = 1'b0;
    win_idx  = '1;
    best_urg = '1;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (elig[s] && (!win_vld || (urg[s*PRIO_W +: PRIO_W] < best_urg))) begin
        win_vld  = 1'b1;
        win_idx  = IDX_W'(s);
        best_urg = urg[s*PRIO_W +: PRIO_W];
      end
    end
  end

  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ((int'(win_idx) < NUM_SRC) && elig[win_idx])); // R5

  AST_NO_WINNER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld |-> (elig == '0)); // R6
endmodule

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 90,
  parameter int unsigned PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic               bus_wr_en,
  input  logic [5:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC + 1);

  logic rst_meta_q, rst_sync_n;
  logic live_q;

  logic [NUM_SRC-1:0]        cls_q, msk_q, pnd_q;
  logic [NUM_SRC*PRIO_W-1:0] urg_q;

  logic [NUM_CLS-1:0][NUM_SRC-1:0] cls_elig;
  logic [NUM_CLS-1:0]              cls_vld;
  logic [NUM_CLS-1:0][IDX_W-1:0]   cls_idx;
  logic [NUM_CLS-1:0]              out_d, out_q;
  logic [NUM_CLS-1:0][IDX_W-1:0]   idx_d, idx_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) live_q <= 1'b0;
    else             live_q <= 1'b1;
  end

  irc_regs #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src_req  (src_req),
    .wr_en    (bus_wr_en),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .norm_idx (idx_q[CLS_NORM]),
    .fast_idx (idx_q[CLS_FAST]),
    .rdata    (bus_rdata),
    .cls_q    (cls_q),
    .msk_q    (msk_q),
    .pnd_q    (pnd_q),
    .urg_q    (urg_q)
  );

  assign cls_elig[CLS_NORM] = pnd_q & ~msk_q & ~cls_q;
  assign cls_elig[CLS_FAST] = pnd_q & ~msk_q &  cls_q;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    irc_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .IDX_W   (IDX_W)
    ) u_arb (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .elig    (cls_elig[c]),
      .urg     (urg_q),
      .win_vld (cls_vld[c]),
      .win_idx (cls_idx[c])
    );
  end

  always_comb begin
    for (int c = 0; c < NUM_CLS; c++) begin
      out_d[c] = cls_vld[c];
      idx_d[c] = cls_vld[c] ? cls_idx[c] : '1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= '0;
      idx_q <= '1;
    end else begin
      out_q <= out_d;
      idx_q <= idx_d;
    end
  end

  assign irq_o = out_q[CLS_NORM];
  assign fiq_o = out_q[CLS_FAST];

  AST_NORM_LINE_TRACKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live_q |-> (irq_o == $past(|(pnd_q & ~msk_q & ~cls_q)))); // R4

  AST_FAST_LINE_TRACKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live_q |-> (fiq_o == $past(|(pnd_q & ~msk_q & cls_q)))); // R7

  AST_NORM_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_o |-> (idx_q[CLS_NORM] == '1)); // R6

  AST_FAST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fiq_o |-> (idx_q[CLS_FAST] == '1)); // R6

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o |-> (int'(idx_q[CLS_NORM]) < NUM_SRC)); // R6
endmodule

// File: tb/tb_irc_ctrl.sv
`timescale 1ns/1ps
module tb_irc_ctrl;
  localparam int NSRC = 90;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NSRC-1:0] src_req;
  logic        bus_wr_en;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural model state
  bit m_cls [NSRC];
  bit m_msk [NSRC];
  bit m_pnd [NSRC];
  int m_urg [NSRC];
  bit m_irq, m_fiq;
  int m_nidx, m_fidx;

  always #10 clk = ~clk;

  irc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic int pick(int c);
    int best = 127;
    int bu = 99;
    for (int s = 0; s < NSRC; s++)
      if (m_pnd[s] && !m_msk[s] && (int'(m_cls[s]) == c) && m_urg[s] < bu) begin
        bu = m_urg[s];
        best = s;
      end
    return best;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSRC; s++) begin
        m_cls[s] = 0; m_msk[s] = 1; m_pnd[s] = 0; m_urg[s] = 0;
      end
      m_irq = 0; m_fiq = 0; m_nidx = 127; m_fidx = 127;
    end else begin
      m_nidx = pick(0);
      m_fidx = pick(1);
      m_irq = (m_nidx != 127);
      m_fiq = (m_fidx != 127);
      for (int s = 0; s < NSRC; s++) begin
        bit clr;
        clr = bus_wr_en && (int'(bus_addr) == 8 + s/32) && bus_wdata[s%32];
        m_pnd[s] = (m_pnd[s] && !clr) || src_req[s];
        if (bus_wr_en && int'(bus_addr) == s/32)     m_cls[s] = bus_wdata[s%32];
        if (bus_wr_en && int'(bus_addr) == 4 + s/32) m_msk[s] = bus_wdata[s%32];
        if (bus_wr_en && int'(bus_addr) == 16 + s/8) m_urg[s] = int'(bus_wdata[(s%8)*4 +: 4]);
      end
    end
  end

  function automatic logic [31:0] exp_word(int a);
    logic [31:0] w = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (a == s/32)      w[s%32] = m_cls[s];
      if (a == 4 + s/32)  w[s%32] = m_msk[s];
      if (a == 8 + s/32)  w[s%32] = m_pnd[s];
      if (a == 16 + s/8)  w[(s%8)*4 +: 4] = 4'(m_urg[s]);
    end
    if (a == 32) w = 32'(m_nidx);
    if (a == 33) w = 32'(m_fidx);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // line levels against the model on every falling edge (R4, R7)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq_o == m_irq, "R4 irq line", 32'(irq_o), 32'(m_irq));
      chk(fiq_o == m_fiq, "R7 fiq line", 32'(fiq_o), 32'(m_fiq));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string req);
    bus_wr_en = 1'b0; bus_addr = 6'(a);
    #2;
    chk(bus_rdata == exp, req, bus_rdata, exp);
    chk(exp_word(a) == exp, {req, " model"}, exp_word(a), exp);
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_req[s] = 1'b1;
    @(negedge clk); src_req[s] = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_req = '0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(irq_o == 1'b0 && fiq_o == 1'b0, "R1 lines low", {30'd0, irq_o, fiq_o}, 32'd0);
    rd(0, 32'h0, "R1 class w0"); rd(2, 32'h0, "R1 class w2");
    rd(4, 32'hffff_ffff, "R1 mask w0"); rd(5, 32'hffff_ffff, "R1 mask w1");
    rd(6, 32'h03ff_ffff, "R1 mask w2");
    rd(8, 32'h0, "R1 pend w0"); rd(16, 32'h0, "R1 urg w0");
    rd(32, 32'd127, "R1 nidx"); rd(33, 32'd127, "R1 fidx");

    // R8 unused bits and map
    wr(2, 32'hffff_ffff); step();
    rd(2, 32'h03ff_ffff, "R8 class top bits");
    wr(2, 32'h0);
    rd(40, 32'h0, "R8 unmapped word");
    wr(4, 0); wr(5, 0); wr(6, 0); step();
    rd(6, 32'h0, "R8 mask w2 written");

    // R2 sticky pending, R4 line, R6 index
    pulse(5); step();
    rd(8, 32'h0000_0020, "R2 pend holds after drop");
    chk(irq_o == 1'b1, "R4 irq asserted", 32'(irq_o), 32'd1);
    rd(32, 32'd5, "R6 nidx src5");

    // R5 urgency ordering
    wr(24, 32'h0100_0000);  // src70 urgency 1
    wr(21, 32'h0000_0003);  // src40 urgency 3
    wr(16, 32'h0050_0000);  // src5 urgency 5
    pulse(40); pulse(70); step();
    rd(32, 32'd70, "R5 most urgent wins");
    wr(19, 32'h0300_0000);  // src30 urgency 3
    pulse(30);
    wr(10, 32'h0000_0040);  // clear src70
    step();
    rd(10, 32'h0, "R3 w1c clears");
    rd(32, 32'd30, "R5 tie lower number");

    // R3 write of zero has no effect
    wr(8, 32'h0); step();
    rd(8, 32'h4000_0020, "R3 zero write keeps w0");
    rd(9, 32'h0000_0100, "R3 zero write keeps w1");

    // R7 fast class beside active normal class
    wr(1, 32'h0000_0100); step();
    chk(fiq_o == 1'b1 && irq_o == 1'b1, "R7 both lines", {30'd0, irq_o, fiq_o}, 32'd3);
    rd(33, 32'd40, "R6 fidx src40");
    rd(32, 32'd30, "R6 nidx src30");

    // R4 masking drops the line
    wr(5, 32'h0000_0100); step();
    chk(fiq_o == 1'b0, "R4 fiq drops on mask", 32'(fiq_o), 32'd0);
    rd(33, 32'd127, "R6 fidx idle");
    rd(9, 32'h0000_0100, "R4 mask keeps pend");

    // R3 set wins over simultaneous clear
    @(negedge clk); src_req[30] = 1'b1;
    bus_wr_en = 1'b1; bus_addr = 6'd8; bus_wdata = 32'h4000_0000;
    @(negedge clk); bus_wr_en = 1'b0; src_req[30] = 1'b0;
    step();
    rd(8, 32'h4000_0020, "R3 set beats clear");
    wr(8, 32'h4000_0020); step();
    rd(8, 32'h0, "R3 clear both");
    chk(irq_o == 1'b0, "R4 irq drops after clear", 32'(irq_o), 32'd0);
    rd(32, 32'd127, "R6 nidx idle");

    // boundary sources 0 and 89
    pulse(89); pulse(0); step();
    rd(10, 32'h0200_0000, "R8 src89 bit");
    rd(32, 32'd0, "R5 src0 over src89");
    wr(8, 32'h1); step();
    rd(32, 32'd89, "R5 src89 remains");
    wr(10, 32'h0200_0000); step();

    // randomized traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      for (int s = 0; s < NSRC; s++) src_req[s] = ($urandom % 40 == 0);
      if (i % 8 == 7) begin
        int pickw;
        int a;
        pickw = $urandom % 6;
        case (pickw)
          0: a = $urandom % 3;
          1: a = 4 + $urandom % 3;
          2: a = 8 + $urandom % 3;
          3: a = 16 + $urandom % 12;
          4: a = 32;
          default: a = 33;
        endcase
        bus_wr_en = 1'b0; bus_addr = 6'(a);
        #2;
        chk(bus_rdata == exp_word(a), "R8 random readback", bus_rdata, exp_word(a));
      end else if ($urandom % 3 == 0) begin
        int pickw;
        pickw = $urandom % 4;
        bus_wr_en = 1'b1;
        bus_wdata = $urandom;
        case (pickw)
          0: bus_addr = 6'($urandom % 3);
          1: begin bus_addr = 6'(4 + $urandom % 3); bus_wdata = $urandom & $urandom; end
          2: bus_addr = 6'(8 + $urandom % 3);
          default: bus_addr = 6'(16 + $urandom % 12);
        endcase
      end else begin
        bus_wr_en = 1'b0;
      end
    end
    @(negedge clk); bus_wr_en = 1'b0; src_req = '0;
    step();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule